// File: doc/BRIEF.md
# Resampling Step Factor Calculator

This block turns a layer's source and destination rectangle sizes into the fixed-point step factors that program a resampling scaler. It also picks, per axis, whether the upscale or the downscale filter coefficients apply. Two scaler flavours are supported. The polyphase flavour uses a phase-offset formula with a post-division guard. The simple flavour uses a plain ratio with ten fractional bits.

A single start pulse latches the four sizes and the mode. One evaluation cycle then decides between bypass, error and computation. When computation is needed, one shared restoring divider runs first for the horizontal axis and then for the vertical axis. All results are published together with a one-cycle done pulse. They are held until the next accepted start. The coefficient words themselves (sixteen horizontal, eight vertical) live outside this block; only the selection bits leave it.

Top module: `scale_step_calc`

## Requirements
- R1: When source equals destination on both axes, in either mode, the run ends with enable_o=0, err_o=0, both factors 0 and both downscale bits 0.
- R2: With poly_i=1 (polyphase), each axis factor is floor(256*(8*(src-1) - phi) / (dst-1)), with phi = 4 on both axes by default.
- R3: In polyphase mode, if floor((factor*(dst-1) + 256*phi)/2048) exceeds src-1, the factor is reduced by one. The published factor therefore always satisfies factor*(dst-1) + 256*phi <= 2048*(src-1).
- R4: With poly_i=0 (simple), each axis factor is floor(1024*src/dst).
- R5: On a successful run, x_down_o is 1 exactly when dst_w < src_w, and y_down_o is 1 exactly when dst_h < src_h.
- R6: When not bypassed, a polyphase run with any size below 2, or a simple run with a zero destination, ends with err_o=1, enable_o=0, factors 0 and downscale bits 0.
- R7: done_o is high for one cycle when a run completes; the outputs are valid in that cycle and hold their values until the next accepted start.
- R8: A start pulse that arrives while a run is in progress is ignored: it neither changes that run's result nor produces an extra completion.
- R9: After reset, every output is 0.
- R10: A run that is neither bypassed nor in error ends with enable_o=1 and err_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when the block is idle |
| poly_i | input | 1 | 1 = polyphase factor, 0 = simple ratio |
| src_w_i | input | SIZE_W | Source width |
| src_h_i | input | SIZE_W | Source height |
| dst_w_i | input | SIZE_W | Destination width |
| dst_h_i | input | SIZE_W | Destination height |
| enable_o | output | 1 | Scaler enable |
| x_factor_o | output | SIZE_W+11 | Horizontal step factor |
| y_factor_o | output | SIZE_W+11 | Vertical step factor |
| x_down_o | output | 1 | Horizontal downscale coefficient select |
| y_down_o | output | 1 | Vertical downscale coefficient select |
| err_o | output | 1 | Sizes cannot be divided for the chosen mode |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check the following against sizes captured at start: the zero outputs of a bypass, the zero outputs of an error, the downscale selection, and the trimmed polyphase bound on both axes. They also check that results stay frozen while idle and that enable and error never coincide. Only the bench's sweeps can show that the factor values are exact quotients for each mode across the full size range. The sweeps also show that the bypass wins over the error conditions, and that a start arriving mid-run leaves the earlier result intact.

// File: rtl/scale_pkg.sv
package scale_pkg;
  localparam int POLY_SHIFT   = 11;  // 256*8 = 2^11
  localparam int SIMPLE_SHIFT = 10;  // 1024
  localparam int PHASE_SHIFT  = 8;   // 256*phi

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_DIVX,
    ST_DIVY
  } step_state_e;
endpackage

// File: rtl/step_divider.sv
module step_divider #(
  parameter int W = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    trial, diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, den_q};
    fits  = ~diff[W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        den_q <= den_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/axis_prep.sv
module axis_prep import scale_pkg::*; #(
  parameter int SIZE_W = 12,
  parameter int FAC_W  = SIZE_W + POLY_SHIFT,
  parameter int PHI    = 4
) (
  input  logic [SIZE_W-1:0] src_i,
  input  logic [SIZE_W-1:0] dst_i,
  input  logic              poly_i,
  output logic [FAC_W-1:0]  num_o,
  output logic [FAC_W-1:0]  den_o,
  output logic              same_o,
  output logic              bad_o,
  output logic              down_o
);
  localparam logic [FAC_W-1:0]  ONE_F   = FAC_W'(1);
  localparam logic [FAC_W-1:0]  PHASE_F = FAC_W'(PHI << PHASE_SHIFT);
  localparam logic [SIZE_W-1:0] TWO_S   = SIZE_W'(2);

  logic [FAC_W-1:0] src_x, dst_x, num_poly, num_simple;

  always_comb begin
    src_x      = FAC_W'(src_i);
    dst_x      = FAC_W'(dst_i);
    num_poly   = ((src_x - ONE_F) << POLY_SHIFT) - PHASE_F;
    num_simple = src_x << SIMPLE_SHIFT;
    num_o      = poly_i ? num_poly : num_simple;
    den_o      = poly_i ? (dst_x - ONE_F) : dst_x;
    same_o     = (src_i == dst_i);
    bad_o      = poly_i ? ((dst_i < TWO_S) || (src_i < TWO_S)) : (dst_i == '0);
    down_o     = (dst_i < src_i);
  end
endmodule

// File: rtl/step_trim.sv
module step_trim import scale_pkg::*; #(
  parameter int SIZE_W = 12,
  parameter int FAC_W  = SIZE_W + POLY_SHIFT,
  parameter int PHI    = 4
) (
  input  logic [FAC_W-1:0]  quo_i,
  input  logic [SIZE_W-1:0] src_i,
  input  logic [SIZE_W-1:0] dst_i,
  input  logic              poly_i,
  output logic [FAC_W-1:0]  fac_o
);
  localparam int PW = FAC_W + SIZE_W + 1;
  localparam logic [PW-1:0] PHASE_P = PW'(PHI << PHASE_SHIFT);
  localparam logic [PW-1:0] ONE_P   = PW'(1);

  logic [PW-1:0] prod, reach, last;
  logic          over;

  always_comb begin
    prod  = PW'(quo_i) * PW'(dst_i - 1'b1);
    reach = (prod + PHASE_P) >> POLY_SHIFT;
    last  = PW'(src_i) - ONE_P;
    over  = poly_i && (reach > last);
    fac_o = over ? (quo_i - 1'b1) : quo_i;
  end
endmodule

// File: rtl/scale_step_calc.sv
module scale_step_calc import scale_pkg::*; #(
  parameter int SIZE_W = 12,
  parameter int PHI_X  = 4,
  parameter int PHI_Y  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         poly_i,
  input  logic [SIZE_W-1:0]            src_w_i,
  input  logic [SIZE_W-1:0]            src_h_i,
  input  logic [SIZE_W-1:0]            dst_w_i,
  input  logic [SIZE_W-1:0]            dst_h_i,
  output logic                         enable_o,
  output logic [SIZE_W+POLY_SHIFT-1:0] x_factor_o,
  output logic [SIZE_W+POLY_SHIFT-1:0] y_factor_o,
  output logic                         x_down_o,
  output logic                         y_down_o,
  output logic                         err_o,
  output logic                         done_o
);
  localparam int FAC_W = SIZE_W + POLY_SHIFT;

  step_state_e       state_q;
  logic              busy;
  logic              mode_q;
  logic [SIZE_W-1:0] src_q [2];
  logic [SIZE_W-1:0] dst_q [2];
  logic [FAC_W-1:0]  num_a [2];
  logic [FAC_W-1:0]  den_a [2];
  logic [FAC_W-1:0]  fac_a [2];
  logic [1:0]        same_a, bad_a, down_a;
  logic              axis_q, div_go_q, div_done;
  logic [FAC_W-1:0]  div_quo, x_tmp_q;

  logic              en_q, err_q, xd_q, yd_q, done_q;
  logic [FAC_W-1:0]  fx_q, fy_q;

  assign busy = (state_q != ST_IDLE);

  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam int PHI = (a == 0) ? PHI_X : PHI_Y;

    axis_prep #(.SIZE_W(SIZE_W), .FAC_W(FAC_W), .PHI(PHI)) u_prep (
      .src_i  (src_q[a]),
      .dst_i  (dst_q[a]),
      .poly_i (mode_q),
      .num_o  (num_a[a]),
      .den_o  (den_a[a]),
      .same_o (same_a[a]),
      .bad_o  (bad_a[a]),
      .down_o (down_a[a])
    );

    step_trim #(.SIZE_W(SIZE_W), .FAC_W(FAC_W), .PHI(PHI)) u_trim (
      .quo_i  (div_quo),
      .src_i  (src_q[a]),
      .dst_i  (dst_q[a]),
      .poly_i (mode_q),
      .fac_o  (fac_a[a])
    );
  end

  step_divider #(.W(FAC_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (div_go_q),
    .num_i  (num_a[axis_q]),
    .den_i  (den_a[axis_q]),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= 1'b0;
      for (int a = 0; a < 2; a++) begin
        src_q[a] <= '0;
        dst_q[a] <= '0;
      end
      axis_q   <= 1'b0;
      div_go_q <= 1'b0;
      x_tmp_q  <= '0;
      en_q     <= 1'b0;
      err_q    <= 1'b0;
      xd_q     <= 1'b0;
      yd_q     <= 1'b0;
      fx_q     <= '0;
      fy_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      div_go_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            src_q[0] <= src_w_i;
            src_q[1] <= src_h_i;
            dst_q[0] <= dst_w_i;
            dst_q[1] <= dst_h_i;
            mode_q   <= poly_i;
            state_q  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (&same_a || |bad_a) begin
            // bypass takes precedence over the error conditions
            en_q    <= 1'b0;
            err_q   <= ~&same_a;
            xd_q    <= 1'b0;
            yd_q    <= 1'b0;
            fx_q    <= '0;
            fy_q    <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            axis_q   <= 1'b0;
            div_go_q <= 1'b1;
            state_q  <= ST_DIVX;
          end
        end
        ST_DIVX: begin
          if (div_done) begin
            x_tmp_q  <= fac_a[0];
            axis_q   <= 1'b1;
            div_go_q <= 1'b1;
            state_q  <= ST_DIVY;
          end
        end
        ST_DIVY: begin
          if (div_done) begin
            fx_q    <= x_tmp_q;
            fy_q    <= fac_a[1];
            xd_q    <= down_a[0];
            yd_q    <= down_a[1];
            en_q    <= 1'b1;
            err_q   <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign enable_o   = en_q;
  assign err_o      = err_q;
  assign x_factor_o = fx_q;
  assign y_factor_o = fy_q;
  assign x_down_o   = xd_q;
  assign y_down_o   = yd_q;
  assign done_o     = done_q;
endmodule

// File: rtl/scale_step_chk.sv
module scale_step_chk import scale_pkg::*; #(
  parameter int SIZE_W = 12,
  parameter int PHI_X  = 4,
  parameter int PHI_Y  = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         start_i,
  input logic                         busy_i,
  input logic                         poly_i,
  input logic [SIZE_W-1:0]            src_w_i,
  input logic [SIZE_W-1:0]            src_h_i,
  input logic [SIZE_W-1:0]            dst_w_i,
  input logic [SIZE_W-1:0]            dst_h_i,
  input logic                         enable_o,
  input logic [SIZE_W+POLY_SHIFT-1:0] x_factor_o,
  input logic [SIZE_W+POLY_SHIFT-1:0] y_factor_o,
  input logic                         x_down_o,
  input logic                         y_down_o,
  input logic                         err_o,
  input logic                         done_o
);
  localparam int FAC_W = SIZE_W + POLY_SHIFT;
  localparam int PW    = FAC_W + SIZE_W + 2;

  logic              c_poly;
  logic [SIZE_W-1:0] c_sw, c_sh, c_dw, c_dh;
  logic [PW-1:0]     x_lhs, x_rhs, y_lhs, y_rhs;
  logic              c_same;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_poly <= 1'b0;
      c_sw   <= '0;
      c_sh   <= '0;
      c_dw   <= '0;
      c_dh   <= '0;
    end else if (start_i && !busy_i) begin
      c_poly <= poly_i;
      c_sw   <= src_w_i;
      c_sh   <= src_h_i;
      c_dw   <= dst_w_i;
      c_dh   <= dst_h_i;
    end
  end

  always_comb begin
    c_same = (c_sw == c_dw) && (c_sh == c_dh);
    x_lhs  = PW'(x_factor_o) * PW'(c_dw - 1'b1) + PW'(PHI_X << PHASE_SHIFT);
    x_rhs  = PW'(c_sw - 1'b1) << POLY_SHIFT;
    y_lhs  = PW'(y_factor_o) * PW'(c_dh - 1'b1) + PW'(PHI_Y << PHASE_SHIFT);
    y_rhs  = PW'(c_sh - 1'b1) << POLY_SHIFT;
  end

  p_bypass_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && c_same) |-> (!enable_o && !err_o && x_factor_o == '0 && y_factor_o == '0));

  p_trim_bound_x_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && enable_o && c_poly) |-> (x_lhs <= x_rhs));

  p_trim_bound_y_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && enable_o && c_poly) |-> (y_lhs <= y_rhs));

  p_down_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && enable_o) |-> (x_down_o == (c_dw < c_sw) && y_down_o == (c_dh < c_sh)));

  p_err_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (!enable_o && x_factor_o == '0 && y_factor_o == '0 && !x_down_o && !y_down_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> ($stable(x_factor_o) && $stable(y_factor_o) &&
                               $stable(enable_o) && $stable(err_o)));

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i);

  p_en_err_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enable_o && err_o));
endmodule

bind scale_step_calc scale_step_chk #(.SIZE_W(SIZE_W), .PHI_X(PHI_X), .PHI_Y(PHI_Y)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_i     (busy),
  .poly_i     (poly_i),
  .src_w_i    (src_w_i),
  .src_h_i    (src_h_i),
  .dst_w_i    (dst_w_i),
  .dst_h_i    (dst_h_i),
  .enable_o   (enable_o),
  .x_factor_o (x_factor_o),
  .y_factor_o (y_factor_o),
  .x_down_o   (x_down_o),
  .y_down_o   (y_down_o),
  .err_o      (err_o),
  .done_o     (done_o)
);

// File: tb/sim_scale_step_calc.sv
`timescale 1ns/1ps
module sim_scale_step_calc;
  localparam int SW = 5;
  localparam int FW = SW + 11;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          poly_i = 1'b0;
  logic [SW-1:0] src_w_i = '0, src_h_i = '0, dst_w_i = '0, dst_h_i = '0;
  logic          enable_o, x_down_o, y_down_o, err_o, done_o;
  logic [FW-1:0] x_factor_o, y_factor_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;

  scale_step_calc #(.SIZE_W(SW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .poly_i(poly_i),
    .src_w_i(src_w_i), .src_h_i(src_h_i), .dst_w_i(dst_w_i), .dst_h_i(dst_h_i),
    .enable_o(enable_o), .x_factor_o(x_factor_o), .y_factor_o(y_factor_o),
    .x_down_o(x_down_o), .y_down_o(y_down_o), .err_o(err_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic int ref_fac(input bit poly, input int s, input int d);
    int f, m;
    if (poly) begin
      f = (256 * (8 * (s - 1) - 4)) / (d - 1);
      m = (f * (d - 1) + 1024) / 2048;
      if (m > s - 1) f--;
    end else begin
      f = (1024 * s) / d;
    end
    return f;
  endfunction

  task automatic wait_done(output bit seen);
    int w = 0;
    while (!done_o && w < 200) begin
      @(negedge clk_i);
      w++;
    end
    seen = done_o;
  endtask

  task automatic compare(input bit poly, input int sw, input int sh, input int dw, input int dh);
    bit byp, bad;
    int ex, ey;
    byp = (sw == dw) && (sh == dh);
    bad = poly ? (dw < 2 || dh < 2 || sw < 2 || sh < 2) : (dw == 0 || dh == 0);
    if (byp) begin
      chk(!enable_o && !err_o && x_factor_o == 0 && y_factor_o == 0 && !x_down_o && !y_down_o,
          "R1 bypass", {enable_o, err_o, x_down_o, y_down_o, x_factor_o, y_factor_o}, 0);
    end else if (bad) begin
      chk(err_o && !enable_o && x_factor_o == 0 && y_factor_o == 0 && !x_down_o && !y_down_o,
          "R6 error", {enable_o, err_o, x_down_o, y_down_o, x_factor_o, y_factor_o},
          longint'(1) << (2 + 2 * FW));
    end else begin
      ex = ref_fac(poly, sw, dw);
      ey = ref_fac(poly, sh, dh);
      chk(enable_o && !err_o, "R10 enable", {enable_o, err_o}, 2);
      chk(x_factor_o == FW'(ex), poly ? "R2 x factor" : "R4 x factor", x_factor_o, ex);
      chk(y_factor_o == FW'(ey), poly ? "R2 y factor" : "R4 y factor", y_factor_o, ey);
      chk(x_down_o == (dw < sw) && y_down_o == (dh < sh), "R5 down select",
          {x_down_o, y_down_o}, {dw < sw, dh < sh});
      if (poly) begin
        chk(longint'(x_factor_o) * (dw - 1) + 1024 <= longint'(2048) * (sw - 1), "R3 x bound",
            longint'(x_factor_o) * (dw - 1) + 1024, longint'(2048) * (sw - 1));
        chk(longint'(y_factor_o) * (dh - 1) + 1024 <= longint'(2048) * (sh - 1), "R3 y bound",
            longint'(y_factor_o) * (dh - 1) + 1024, longint'(2048) * (sh - 1));
      end
    end
  endtask

  task automatic run_case(input bit poly, input int sw, input int sh, input int dw, input int dh);
    bit seen;
    logic [FW-1:0] hx, hy;
    @(negedge clk_i);
    poly_i = poly;
    src_w_i = SW'(sw); src_h_i = SW'(sh); dst_w_i = SW'(dw); dst_h_i = SW'(dh);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(seen);
    if (!seen) begin
      chk(1'b0, "R7 no done", 0, 1);
    end else begin
      compare(poly, sw, sh, dw, dh);
      hx = x_factor_o;
      hy = y_factor_o;
      @(negedge clk_i);
      chk(!done_o && x_factor_o == hx && y_factor_o == hy, "R7 pulse and hold",
          {done_o, x_factor_o}, {1'b0, hx});
    end
  endtask

  initial begin
    bit seen;
    int extra;
    repeat (3) @(negedge clk_i);
    chk(!enable_o && !err_o && !done_o && !x_down_o && !y_down_o &&
        x_factor_o == 0 && y_factor_o == 0, "R9 reset state",
        {enable_o, err_o, done_o, x_factor_o, y_factor_o}, 0);
    rst_ni = 1'b1;

    // R1: bypass in both modes, including a size that would otherwise be an error
    run_case(1'b1, 5, 5, 5, 5);
    run_case(1'b0, 17, 9, 17, 9);
    run_case(1'b1, 1, 1, 1, 1);
    run_case(1'b0, 0, 0, 0, 0);
    // R6: error cases
    run_case(1'b1, 10, 10, 1, 4);
    run_case(1'b1, 1, 8, 6, 3);
    run_case(1'b0, 10, 10, 5, 0);
    // R2 R4 R5: sweep horizontal axis in both modes
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 32; s++)
        for (int d = 0; d < 32; d++)
          run_case(m[0], s, 9, d, 6);
    // vertical axis sweep
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 32; s += 3)
        for (int d = 0; d < 32; d += 3)
          run_case(m[0], 12, s, 12, d);

    // R8: a second start during a run is ignored
    @(negedge clk_i);
    poly_i = 1'b1;
    src_w_i = 5'd20; src_h_i = 5'd30; dst_w_i = 5'd9; dst_h_i = 5'd31;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    poly_i = 1'b0;
    src_w_i = 5'd3; src_h_i = 5'd4; dst_w_i = 5'd7; dst_h_i = 5'd2;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(seen);
    chk(seen, "R8 first run completes", seen, 1);
    if (seen) compare(1'b1, 20, 30, 9, 31);
    extra = 0;
    repeat (80) begin
      @(negedge clk_i);
      if (done_o) extra++;
    end
    chk(extra == 0, "R8 no extra done", extra, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule